// File: doc/BRIEF.md
# Auto-Reload 8-Bit PWM Channel

This block is one pulse-width output channel paired with its own free-running 16-bit timebase. The timebase advances by one on each clock where the `tick` input is high. Only the low byte of the timebase takes part in pulse generation, so one output period is 256 ticks. The channel keeps two compare bytes:

- a working byte that the comparator uses;
- a staging byte that software loads with the next duty setting.

Each time the low byte of the timebase wraps, the working byte is refilled from the staging byte. A new duty setting therefore starts at a period boundary, and no period is ever cut short or stretched.

The output is set when the timebase low byte equals the working byte. It is cleared when the low byte wraps from 0xFF to 0x00. The high time per period is therefore 256 minus the staging value, counted in ticks.

Software programs the channel through a small write port with three addresses. Writing either compare byte also changes the compare-enable bit as a side effect. This forces a fixed order of writes: the working byte first, then the staging byte.

Top module: `pwm8_reload_channel`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the following to 0: the timebase, both compare bytes, compare-enable, pwm-enable and `pwm_out`.
- R2: `count` increases by one, wrapping from 0xFFFF to 0x0000, after each clock edge where `tick` is 1. It holds its value after each edge where `tick` is 0.
- R3: A write is a clock edge with `wr_en` high. The address decides its effect, which is visible from the next cycle:
  - address 0 loads the working compare byte and clears compare-enable;
  - address 1 loads the staging compare byte and sets compare-enable;
  - address 2 loads compare-enable from `wr_data[0]` and pwm-enable from `wr_data[1]`;
  - address 3 changes nothing.
- R4: When compare-enable or pwm-enable is 0 during a cycle, `pwm_out` is 0 in the following cycle.
- R5: With both enables set, `pwm_out` rises only in the cycle after a cycle where `count[7:0]` equals the working compare byte.
- R6: Once set, the output stays high for every remaining count of the period. It falls in the cycle after the tick that moves `count[7:0]` from 0xFF to 0x00, unless 0x00 itself matches.
- R7: On the tick that wraps the low byte, the working byte is loaded from the staging byte. If a write to address 0 happens in the same cycle, the written value is loaded instead.
- R8: With `tick` held at 1, each 256-cycle window in steady state holds exactly 256 − H cycles of high output, where H is the staging byte. H = 0x00 gives a constant high output.
- R9: Writing only the working byte, which leaves compare-enable at 0, keeps `pwm_out` low. This is how a 0% duty cycle is produced.
- R10: A wrap has priority over a match at count 0xFF in clearing the held-high state. A staging byte of 0xFF therefore gives exactly one count of high time per period, not a constant high output.
- R11: Changing the staging byte in mid-period leaves the rest of that period unchanged. The new duty applies from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable for the timebase |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 working byte, 1 staging byte, 2 mode bits |
| wr_data | input | 8 | Write data |
| count | output | 16 | Current timebase value |
| pwm_out | output | 1 | Registered PWM output |

## Verification
A working compare byte that has gone wrong shows up in the period after it is loaded. The rising edge of `pwm_out` lands at the wrong count, and the per-clock comparison against the bench model flags it within one clock of that count. A held-high flag that fails to clear on wrap, or that clears too early, shows up as a missing or extra high cycle at the period boundary, within one clock. A wrong enable bit after a byte write shows up two clocks after the write, as output activity where none is allowed. A wrong timebase shows up at once on `count`.

// File: rtl/pwm8_reload_channel.sv
module pwm8_reload_channel #(
  parameter int CNT_W = 16,
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CMP_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             pwm_out
);

  localparam logic [CMP_W-1:0] TOP = '1;

  logic [CMP_W-1:0] cmp_lo, cmp_hi;
  logic             cmp_en, pwm_en, hold_q;

  wire [CMP_W-1:0] cnt_lo   = count[CMP_W-1:0];
  wire             mode_act = cmp_en & pwm_en;
  wire             hit      = (cnt_lo == cmp_lo);
  wire             wrap     = tick & (cnt_lo == TOP);
  wire             level    = mode_act & (hold_q | hit);
  wire             wr_lo    = wr_en & (wr_addr == 2'd0);
  wire             wr_hi    = wr_en & (wr_addr == 2'd1);
  wire             wr_md    = wr_en & (wr_addr == 2'd2);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_lo <= '0;
      cmp_hi <= '0;
    end else begin
      if (wr_lo)      cmp_lo <= wr_data;
      else if (wrap)  cmp_lo <= cmp_hi;
      if (wr_hi)      cmp_hi <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_en <= 1'b0;
      pwm_en <= 1'b0;
    end else if (wr_md) begin
      cmp_en <= wr_data[0];
      pwm_en <= wr_data[1];
    end else if (wr_hi) begin
      cmp_en <= 1'b1;
    end else if (wr_lo) begin
      cmp_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      pwm_out <= 1'b0;
    end else begin
      hold_q  <= wrap ? 1'b0 : level;
      pwm_out <= level;
    end
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> count == $past(count) + 1'b1);

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_act |=> !pwm_out);

  // R5
  rise_at_match_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> $past(cnt_lo == cmp_lo));

  // R9
  lo_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> ##1 !pwm_out);

endmodule

// File: tb/tb_pwm8_reload_channel.sv
`timescale 1ns/1ps
module tb_pwm8_reload_channel;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [15:0] count;
  logic        pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  pwm8_reload_channel dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count(count), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  int m_cnt = 0, m_lo = 0, m_hi = 0;
  bit m_ce = 0, m_pe = 0, m_hold = 0, m_out = 0;
  int lo8;
  bit lvl, ovf;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_lo = 0; m_hi = 0;
      m_ce = 0; m_pe = 0; m_hold = 0; m_out = 0;
    end else begin
      lo8 = m_cnt % 256;
      lvl = m_ce && m_pe && (m_hold || lo8 == m_lo);
      ovf = tick && lo8 == 255;
      if (wr_en && wr_addr == 2'd0) m_lo = wr_data;
      else if (ovf)                 m_lo = m_hi;
      if (wr_en && wr_addr == 2'd1) m_hi = wr_data;
      if (wr_en && wr_addr == 2'd2) begin m_ce = wr_data[0]; m_pe = wr_data[1]; end
      else if (wr_en && wr_addr == 2'd1) m_ce = 1;
      else if (wr_en && wr_addr == 2'd0) m_ce = 0;
      m_hold = ovf ? 0 : lvl;
      m_out  = lvl;
      if (tick) m_cnt = (m_cnt + 1) % 65536;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(pwm_out === m_out, "R5 R6 per-cycle output", int'(pwm_out), int'(m_out));
      chk(count === m_cnt[15:0], "R2 per-cycle count", int'(count), m_cnt);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      h += int'(pwm_out);
    end
  endtask

  task automatic duty(input logic [7:0] h, input string tag);
    int hc;
    wr(2'd2, 8'h02);
    wr(2'd0, h);
    wr(2'd1, h);
    repeat (512) @(negedge clk);
    measure(768, hc);
    chk(hc == 3 * (256 - int'(h)), tag, hc, 3 * (256 - int'(h)));
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    int hc;
    int c0;
    repeat (3) @(negedge clk);
    chk(count == 16'd0, "R1 reset count", int'(count), 0);
    chk(pwm_out == 1'b0, "R1 reset output", int'(pwm_out), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(count == 16'd0, "R2 no tick holds count", int'(count), 0);

    tick = 1'b1;
    duty(8'h00, "R8 duty H=00");
    duty(8'h80, "R8 duty H=80");
    duty(8'hFF, "R10 duty H=FF one count");

    wr(2'd0, 8'h20);
    measure(600, hc);
    chk(hc == 0, "R9 low byte only keeps output low", hc, 0);

    wr(2'd3, 8'h55);
    measure(300, hc);
    chk(hc == 0, "R3 address 3 has no effect", hc, 0);

    wr(2'd2, 8'h03);
    repeat (512) @(negedge clk);
    measure(768, hc);
    chk(hc == 3, "R7 reload from staging byte FF", hc, 3);

    wr(2'd2, 8'h01);
    measure(600, hc);
    chk(hc == 0, "R4 pwm-enable off", hc, 0);

    duty(8'h80, "R8 duty H=80 again");
    while (count[7:0] != 8'h90) @(negedge clk);
    wr(2'd1, 8'h40);
    while (count[7:0] != 8'hC0) @(negedge clk);
    chk(pwm_out == 1'b1, "R11 old duty holds this period", int'(pwm_out), 1);
    while (count[7:0] != 8'h30) @(negedge clk);
    chk(pwm_out == 1'b0, "R11 new period low before 0x40", int'(pwm_out), 0);
    while (count[7:0] != 8'h45) @(negedge clk);
    chk(pwm_out == 1'b1, "R11 new duty high after 0x40", int'(pwm_out), 1);
    while (count[7:0] != 8'h70) @(negedge clk);
    chk(pwm_out == 1'b1, "R11 new duty high at 0x70", int'(pwm_out), 1);

    while (count[7:0] != 8'hFF) @(negedge clk);
    wr(2'd0, 8'h10);
    wr(2'd2, 8'h03);
    while (count[7:0] != 8'h08) @(negedge clk);
    chk(pwm_out == 1'b0, "R7 write wins over reload, low before 0x10", int'(pwm_out), 0);
    while (count[7:0] != 8'h20) @(negedge clk);
    chk(pwm_out == 1'b1, "R7 write wins over reload, high at 0x20", int'(pwm_out), 1);

    c0 = int'(count);
    for (int i = 0; i < 300; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
    end
    chk(int'(count) == (c0 + 100) % 65536, "R2 sparse tick count", int'(count), (c0 + 100) % 65536);
    for (int i = 0; i < 2400; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
    end

    tick = 1'b1;
    while (count != 16'hFFFF) @(negedge clk);
    @(negedge clk);
    chk(count == 16'h0000, "R2 16-bit wrap", int'(count), 0);

    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule